// File: doc/BRIEF.md
# SCSI Initiator Arbitration Sequencer

This block carries out the arbitration step that a SCSI initiator performs before it may select a target. The host requests arbitration by setting an arbitrate bit. The block reacts only to the rising edge of that bit. It first checks whether some other device already holds SEL. If one does, and the host has not set its own SEL command bit, the block reports the loss at once and drives nothing.

Otherwise the block raises its arbitration-in-progress flag. It places its own one-hot ID bit on the data bus and asserts BSY. It then waits a fixed number of clocks: a base count of arbitration units multiplied by a clock conversion factor. When the wait ends, it priority-encodes the data bus. The highest-numbered asserted line is the winner.

- If the winner is this device, the block returns to idle and keeps driving BSY and its ID.
- If another device is the winner, or no line is asserted at all, the block sets the lost flag and releases every line it drives.

Top module: `scsi_arb_seq`

## Requirements
- R1: Arbitration starts only in a clock where `arb_bit_i` is 1 and was 0 in the previous clock, while no arbitration is running. Holding the bit high starts nothing further. The bit's reset history value is 0.
- R2: If a start occurs while `bus_sel_i` is 1 and `own_sel_cmd_i` is 0, the result shows one clock later: `arb_lost_o` is 1, `arb_busy_o` stays 0, and `bsy_oe_o` and `data_oe_o` are 0.
- R3: On any other start, one clock later `arb_lost_o` is 0, `arb_busy_o` is 1, `bsy_oe_o` and `data_oe_o` are 1, and `data_o` carries only bit OWN_ID set (default OWN_ID = 5, so 8'h20).
- R4: `arb_busy_o` stays high for exactly ARB_UNITS*CLK_CONV clocks (default 11*2 = 22). The data bus is sampled in the last of those clocks.
- R5: The winner is the highest index i (7 down to 0) with `bus_data_i[i]` = 1.
- R6: If the winner is OWN_ID, `arb_busy_o` falls and `arb_lost_o` stays 0, while `bsy_oe_o`, `data_oe_o` and `data_o` keep their values.
- R7: If the winner is a different index, `arb_busy_o` falls, `arb_lost_o` becomes 1, and `bsy_oe_o`, `data_oe_o` and `data_o` all become 0.
- R8: If `bus_data_i` is all zero at the decision, the outcome is a loss, handled as in R7.
- R9: After reset `arb_busy_o`, `arb_lost_o`, `bsy_oe_o`, `data_oe_o` and `data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arb_bit_i | input | 1 | Arbitrate bit of the mode register (level) |
| own_sel_cmd_i | input | 1 | Host command to assert SEL itself |
| bus_sel_i | input | 1 | SEL as seen on the bus |
| bus_data_i | input | N_IDS | Data bus as seen (wired-OR of all drivers) |
| data_o | output | N_IDS | Own one-hot ID for the data bus |
| data_oe_o | output | 1 | Data bus drive enable |
| bsy_oe_o | output | 1 | BSY drive enable |
| arb_busy_o | output | 1 | Arbitration in progress |
| arb_lost_o | output | 1 | Arbitration lost |

## Verification
The case hardest to reach from the ports is a decision with an all-zero data bus. It cannot happen while the block's own ID is looped back onto the bus. The bench therefore has a loopback switch, which it opens for directed trials with no competitors. Random trials then mix competitor ID patterns both above and below the own ID. Directed trials cover a SEL conflict, a SEL conflict overridden by the own SEL command, and a bit held high after a finished arbitration.

// File: rtl/scsi_arb_pkg.sv
package scsi_arb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } arb_state_e;
endpackage

// File: rtl/arb_rise_det.sv
module arb_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/arb_delay_timer.sv
module arb_delay_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/arb_prio_enc.sv
module arb_prio_enc #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);
  // ascending scan: last hit is the highest index
  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (req_i[i]) begin
        idx_o   = IDX_W'(i);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/scsi_arb_seq.sv
module scsi_arb_seq
  import scsi_arb_pkg::*;
#(
  parameter int unsigned N_IDS     = 8,
  parameter int unsigned OWN_ID    = 5,
  parameter int unsigned ARB_UNITS = 11,
  parameter int unsigned CLK_CONV  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arb_bit_i,
  input  logic             own_sel_cmd_i,
  input  logic             bus_sel_i,
  input  logic [N_IDS-1:0] bus_data_i,
  output logic [N_IDS-1:0] data_o,
  output logic             data_oe_o,
  output logic             bsy_oe_o,
  output logic             arb_busy_o,
  output logic             arb_lost_o
);
  localparam int unsigned DELAY   = ARB_UNITS * CLK_CONV;
  localparam int unsigned CNT_W   = $clog2(DELAY + 1);
  localparam int unsigned IDX_W   = (N_IDS > 1) ? $clog2(N_IDS) : 1;
  localparam logic [N_IDS-1:0] OWN_MASK = N_IDS'(1) << OWN_ID;

  arb_state_e       state_q;
  logic             rise_w, conflict_w, start_w, done_w;
  logic             win_valid_w, won_w;
  logic [IDX_W-1:0] win_idx_w;

  arb_rise_det u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (arb_bit_i),
    .rise_o (rise_w)
  );

  assign conflict_w = bus_sel_i & ~own_sel_cmd_i;
  assign start_w    = (state_q == ST_IDLE) & rise_w & ~conflict_w;

  arb_delay_timer #(.W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_w),
    .load_val_i (CNT_W'(DELAY - 1)),
    .done_o     (done_w)
  );

  arb_prio_enc #(.N(N_IDS)) u_prio (
    .req_i   (bus_data_i),
    .idx_o   (win_idx_w),
    .valid_o (win_valid_w)
  );

  assign won_w = win_valid_w & (win_idx_w == IDX_W'(OWN_ID));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      arb_busy_o <= 1'b0;
      arb_lost_o <= 1'b0;
      bsy_oe_o   <= 1'b0;
      data_oe_o  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (rise_w) begin
            if (conflict_w) begin
              arb_lost_o <= 1'b1;
              arb_busy_o <= 1'b0;
              bsy_oe_o   <= 1'b0;
              data_oe_o  <= 1'b0;
            end else begin
              arb_lost_o <= 1'b0;
              arb_busy_o <= 1'b1;
              bsy_oe_o   <= 1'b1;
              data_oe_o  <= 1'b1;
              state_q    <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (done_w) begin
            arb_busy_o <= 1'b0;
            state_q    <= ST_IDLE;
            if (!won_w) begin
              arb_lost_o <= 1'b1;
              bsy_oe_o   <= 1'b0;
              data_oe_o  <= 1'b0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o = data_oe_o ? OWN_MASK : '0;
endmodule

// File: rtl/scsi_arb_seq_chk.sv
module scsi_arb_seq_chk #(
  parameter int unsigned DELAY = 22
) (
  input logic clk_i,
  input logic rst_ni,
  input logic arb_bit_i,
  input logic rise_i,
  input logic conflict_i,
  input logic arb_busy_o,
  input logic arb_lost_o,
  input logic bsy_oe_o,
  input logic data_oe_o
);
  localparam int unsigned CW = $clog2(DELAY + 2);
  logic [CW-1:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         busy_cnt_q <= '0;
    else if (arb_busy_o) busy_cnt_q <= busy_cnt_q + 1'b1;
    else                 busy_cnt_q <= '0;
  end

  p_start_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arb_busy_o) |-> $past(arb_bit_i));

  p_sel_conflict_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && conflict_i && !arb_busy_o) |=> (arb_lost_o && !arb_busy_o && !bsy_oe_o));

  p_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_busy_o |-> (bsy_oe_o && data_oe_o && !arb_lost_o));

  p_window_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(arb_busy_o) |-> (busy_cnt_q == CW'(DELAY)));

  p_window_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt_q <= CW'(DELAY));

  p_win_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(arb_busy_o) && !arb_lost_o) |-> (bsy_oe_o && data_oe_o));

  p_loss_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arb_lost_o) |-> (!bsy_oe_o && !data_oe_o));
endmodule

bind scsi_arb_seq scsi_arb_seq_chk #(.DELAY(ARB_UNITS * CLK_CONV)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .arb_bit_i  (arb_bit_i),
  .rise_i     (rise_w),
  .conflict_i (conflict_w),
  .arb_busy_o (arb_busy_o),
  .arb_lost_o (arb_lost_o),
  .bsy_oe_o   (bsy_oe_o),
  .data_oe_o  (data_oe_o)
);

// File: tb/scsi_arb_seq_bench.sv
module scsi_arb_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_IDS = 8;
  localparam int OWN_ID = 5;
  localparam int DELAY = 22;
  localparam logic [7:0] OWN_MASK = 8'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arb_bit = 1'b0, own_sel = 1'b0, bus_sel = 1'b0;
  logic [7:0] others = 8'h00;
  logic loopback = 1'b1;
  logic [7:0] data_o;
  logic data_oe, bsy_oe, busy, lost;
  logic [7:0] bus_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_data = others | ((loopback && data_oe) ? data_o : 8'h00);

  scsi_arb_seq u_scsi_arb_seq (
    .clk_i(clk), .rst_ni(rst_n), .arb_bit_i(arb_bit), .own_sel_cmd_i(own_sel),
    .bus_sel_i(bus_sel), .bus_data_i(bus_data), .data_o(data_o),
    .data_oe_o(data_oe), .bsy_oe_o(bsy_oe), .arb_busy_o(busy), .arb_lost_o(lost)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_win(logic [7:0] oth, bit lb);
    logic [7:0] b;
    int hi;
    b = oth | (lb ? OWN_MASK : 8'h00);
    hi = -1;
    for (int i = 0; i < N_IDS; i++) if (b[i]) hi = i;
    return hi == OWN_ID;
  endfunction

  task automatic do_reset();
    arb_bit = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // full arbitration with the given competitors; result checked per R3..R8
  task automatic trial(logic [7:0] oth, bit lb, string tag);
    bit w;
    do_reset();
    others = oth; loopback = lb; bus_sel = 1'b0; own_sel = 1'b0;
    arb_bit = 1'b1;
    @(negedge clk);
    chk({"R3 busy ", tag}, {busy, lost, bsy_oe, data_oe}, 4'b1011);
    chk({"R3 data ", tag}, data_o, OWN_MASK);
    repeat (DELAY - 1) @(negedge clk);
    chk({"R4 still busy ", tag}, busy, 1'b1);
    @(negedge clk);
    w = exp_win(oth, lb);
    chk({"R4 busy fell ", tag}, busy, 1'b0);
    if (w) chk({"R5 R6 win ", tag}, {lost, bsy_oe, data_oe, data_o}, {3'b011, OWN_MASK});
    else   chk({"R5 R7 loss ", tag}, {lost, bsy_oe, data_oe, data_o}, {3'b100, 8'h00});
  endtask

  initial begin
    void'($urandom(32'd20240601));
    do_reset();
    // R9 reset state
    chk("R9 reset", {busy, lost, bsy_oe, data_oe, data_o}, 12'h000);

    // R1 bit held high after a finished arbitration: no restart
    trial(8'h01, 1'b1, "r1_base");
    repeat (5) @(negedge clk);
    chk("R1 held high no restart", {busy, lost, bsy_oe}, 3'b001);
    // R1 drop and raise again: restarts
    arb_bit = 1'b0; @(negedge clk);
    arb_bit = 1'b1; @(negedge clk);
    chk("R1 re-raise restarts", busy, 1'b1);
    arb_bit = 1'b0;
    repeat (DELAY + 2) @(negedge clk);

    // R2 SEL conflict
    do_reset();
    bus_sel = 1'b1; own_sel = 1'b0; others = 8'h00;
    arb_bit = 1'b1; @(negedge clk);
    chk("R2 conflict lost", {busy, lost, bsy_oe, data_oe, data_o}, {4'b0100, 8'h00});
    repeat (3) @(negedge clk);
    chk("R2 no later start", busy, 1'b0);
    // R2 own SEL command overrides conflict
    do_reset();
    bus_sel = 1'b1; own_sel = 1'b1;
    arb_bit = 1'b1; @(negedge clk);
    chk("R2 own sel proceeds", {busy, lost}, 2'b10);
    bus_sel = 1'b0; own_sel = 1'b0;

    // directed corners
    trial(8'h00, 1'b1, "alone");
    trial(8'h40, 1'b1, "higher_r7");
    trial(8'h1F, 1'b1, "all_lower");
    trial(8'h80, 1'b1, "top_id");
    trial(8'h00, 1'b0, "empty_r8");
    trial(8'h10, 1'b0, "lower_noloop_r8");

    // random competitors
    for (int k = 0; k < 40; k++) begin
      logic [7:0] o;
      o = 8'($urandom) & ~OWN_MASK;
      if (k % 3 == 0) o = o & 8'h1F;
      trial(o, 1'b1, "rand");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule